// File: doc/BRIEF.md
# Adapter Memory Window Decoder

This block sits behind a 16 KB memory window on an ISA-style host bus inside a disk-controller adapter. It splits the window into regions and sends each host read or write strobe to the right one: a boot ROM read port, a 128-byte scratch RAM, a control register, a status register, eight bus-controller registers, and a data port. The scratch RAM and the control register are held inside the block. The status value, the controller register file, the ROM contents and the data port buffer are all outside it. The block drives strobes, an index or offset and the write data toward them, and it takes their read data back in.

Only the low 14 bits of the host address take part in decoding, so any higher bits alias. The block captures read data at the clock edge of the read strobe and holds it until the next read. When a control write raises control bit 1 from clear to set, the block sends a one-cycle pulse to the external status logic, which then sets its status flag.

Top module: `mem_window_dec`

## Requirements
- R1: Only address bits 13:0 are decoded, so two addresses that differ only above bit 13 reach the same location.
- R2: With `rom_en` high, reads of offsets 0x0000–0x17FF return `rom_rdata`, and `rom_addr` equals offset bits 12:0. With `rom_en` low, those reads return 0xFF.
- R3: Offsets 0x1800–0x187F reach a 128-byte read/write scratch RAM indexed by address bits 6:0.
- R4: Offsets 0x1C00–0x1C1F read and write the 8-bit control register `ctrl_q`, which reset clears to 0x00.
- R5: Reads of offsets 0x1C20–0x1C3F return `status_in`.
- R6: Offsets 0x1D00–0x1DFF raise `ctl_rd` or `ctl_wr` in the same cycle as the host strobe, with `ctl_idx` set to offset bits 7:5. Reads return `ctl_rdata`.
- R7: Offsets 0x1E00–0x1FFF raise `dp_rd` or `dp_wr` in the same cycle as the host strobe, with `dp_off` set to offset bits 8:0. Reads return `dp_rdata`.
- R8: A control write with data bit 1 set, while `ctrl_q` bit 1 is clear, raises `stat_set` for exactly the one cycle after the write edge. No other write raises it.
- R9: Reads of unmapped offsets return 0xFF. Writes to the ROM region or to unmapped offsets change no state and raise no strobe.
- R10: `bus_rdata` changes only at the clock edge of a read strobe, is valid from the following cycle, and holds until the next read. Reset sets it to 0xFF.
- R11: When a read and a write to the same RAM or control location fall in the same cycle, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Host address; only bits 13:0 decoded |
| bus_rd | input | 1 | Host read strobe, one cycle |
| bus_wr | input | 1 | Host write strobe, one cycle |
| bus_wdata | input | 8 | Host write data, also forwarded to the controller and the data port |
| bus_rdata | output | 8 | Registered read data |
| rom_en | input | 1 | ROM region enable |
| rom_addr | output | 13 | ROM byte address |
| rom_rdata | input | 8 | ROM read data |
| ctrl_q | output | 8 | Control register value |
| status_in | input | 8 | External status register value |
| stat_set | output | 1 | Pulse that sets status flag bit 1 |
| ctl_idx | output | 3 | Controller register index |
| ctl_rd | output | 1 | Controller register read strobe |
| ctl_wr | output | 1 | Controller register write strobe |
| ctl_rdata | input | 8 | Controller register read data |
| dp_off | output | 9 | Data port byte offset |
| dp_rd | output | 1 | Data port read strobe |
| dp_wr | output | 1 | Data port write strobe |
| dp_rdata | input | 8 | Data port read data |

## Verification
A host read and a host write can fall in the same cycle, and when both target the control register this also triggers edge detection on control bit 1. The bench provokes the overlap in two cases. In the first, it asserts both strobes on one scratch RAM byte that holds a known value. In the second, it asserts both strobes on the control register with bit 1 rising. In each case the captured read data must be the old value, the following read must return the new value, and in the control case `stat_set` must pulse in the very next cycle.

// File: rtl/mem_window_dec.sv
module mem_window_dec #(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              rom_en,
  output logic [12:0]       rom_addr,
  input  logic [7:0]        rom_rdata,
  output logic [7:0]        ctrl_q,
  input  logic [7:0]        status_in,
  output logic              stat_set,
  output logic [2:0]        ctl_idx,
  output logic              ctl_rd,
  output logic              ctl_wr,
  input  logic [7:0]        ctl_rdata,
  output logic [8:0]        dp_off,
  output logic              dp_rd,
  output logic              dp_wr,
  input  logic [7:0]        dp_rdata
);
  localparam int OFF_W    = 14;
  localparam int RAM_AW   = 7;
  localparam int RAM_D    = 1 << RAM_AW;
  localparam logic [OFF_W-1:0] ROM_END  = 14'h1800;
  localparam logic [OFF_W-1:0] RAM_BASE = 14'h1800;
  localparam logic [OFF_W-1:0] CTRL_LO  = 14'h1C00;
  localparam logic [OFF_W-1:0] STAT_LO  = 14'h1C20;
  localparam logic [OFF_W-1:0] STAT_HI  = 14'h1C40;
  localparam logic [OFF_W-1:0] REG_LO   = 14'h1D00;
  localparam logic [OFF_W-1:0] DP_LO    = 14'h1E00;
  localparam logic [OFF_W-1:0] DP_HI    = 14'h2000;

  logic [OFF_W-1:0] off;
  logic hit_rom, hit_ram, hit_ctrl, hit_stat, hit_reg, hit_dp, hit_none;
  logic [7:0] ram [RAM_D];
  logic [7:0] rd_mux;
  logic       set_edge;

  assign off      = bus_addr[OFF_W-1:0];
  assign hit_rom  = off < ROM_END;
  assign hit_ram  = (off >= RAM_BASE) && (off < RAM_BASE + RAM_D);
  assign hit_ctrl = (off >= CTRL_LO) && (off < STAT_LO);
  assign hit_stat = (off >= STAT_LO) && (off < STAT_HI);
  assign hit_reg  = (off >= REG_LO) && (off < DP_LO);
  assign hit_dp   = (off >= DP_LO) && (off < DP_HI);
  assign hit_none = !(hit_rom || hit_ram || hit_ctrl || hit_stat || hit_reg || hit_dp);

  assign rom_addr = off[12:0];
  assign ctl_idx  = off[7:5];
  assign ctl_rd   = bus_rd && hit_reg;
  assign ctl_wr   = bus_wr && hit_reg;
  assign dp_off   = off[8:0];
  assign dp_rd    = bus_rd && hit_dp;
  assign dp_wr    = bus_wr && hit_dp;

  assign set_edge = bus_wr && hit_ctrl && bus_wdata[1] && !ctrl_q[1];

  always_comb begin
    rd_mux = 8'hFF;
    if (hit_rom && rom_en) rd_mux = rom_rdata;
    else if (hit_ram)      rd_mux = ram[off[RAM_AW-1:0]];
    else if (hit_ctrl)     rd_mux = ctrl_q;
    else if (hit_stat)     rd_mux = status_in;
    else if (hit_reg)      rd_mux = ctl_rdata;
    else if (hit_dp)       rd_mux = dp_rdata;
  end

  always_ff @(posedge clk) begin
    if (bus_wr && hit_ram) ram[off[RAM_AW-1:0]] <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= 8'h00;
      stat_set  <= 1'b0;
      bus_rdata <= 8'hFF;
    end else begin
      stat_set <= set_edge;
      if (bus_wr && hit_ctrl) ctrl_q <= bus_wdata;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  a_r8_set_rise: assert property (@(posedge clk) disable iff (!rst_n)
    stat_set |-> (ctrl_q[1] && !$past(ctrl_q[1])));
  a_r4_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_wr && hit_ctrl) |-> $stable(ctrl_q));
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bus_rd) |-> $stable(bus_rdata));
  a_r9_unmapped_ff: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd && hit_none) |-> (bus_rdata == 8'hFF));
  a_r6_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl_rd || ctl_wr, dp_rd || dp_wr}));
  a_r2_rom_off_ff: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_rd && hit_rom && !rom_en) |-> (bus_rdata == 8'hFF));
endmodule

// File: tb/mem_window_dec_tb.sv
module mem_window_dec_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [19:0] bus_addr;
  logic        bus_rd, bus_wr, rom_en;
  logic [7:0]  bus_wdata, bus_rdata, rom_rdata, ctrl_q, status_in, ctl_rdata, dp_rdata;
  logic [12:0] rom_addr;
  logic        stat_set, ctl_rd, ctl_wr, dp_rd, dp_wr;
  logic [2:0]  ctl_idx;
  logic [8:0]  dp_off;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  mem_window_dec dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rom_en(rom_en), .rom_addr(rom_addr),
    .rom_rdata(rom_rdata), .ctrl_q(ctrl_q), .status_in(status_in), .stat_set(stat_set),
    .ctl_idx(ctl_idx), .ctl_rd(ctl_rd), .ctl_wr(ctl_wr), .ctl_rdata(ctl_rdata),
    .dp_off(dp_off), .dp_rd(dp_rd), .dp_wr(dp_wr), .dp_rdata(dp_rdata)
  );

  // external models
  assign rom_rdata = rom_addr[7:0] ^ 8'h5A;
  assign ctl_rdata = {5'b10100, ctl_idx};
  assign dp_rdata  = 8'hC3;
  assign status_in = 8'h96;

  // op: 1 write, 2 read | addr | wdata | expected
  localparam int NV = 17;
  localparam logic [37:0] VEC [NV] = '{
    {2'd1, 20'h01800, 8'hA5, 8'h00},
    {2'd1, 20'h0187F, 8'h3C, 8'h00},
    {2'd2, 20'h01800, 8'h00, 8'hA5},
    {2'd2, 20'h0187F, 8'h00, 8'h3C},
    {2'd2, 20'hF1800, 8'h00, 8'hA5},
    {2'd1, 20'h01C00, 8'h81, 8'h00},
    {2'd2, 20'h01C1F, 8'h00, 8'h81},
    {2'd2, 20'h01C20, 8'h00, 8'h96},
    {2'd2, 20'h00123, 8'h00, 8'h79},
    {2'd2, 20'h017FF, 8'h00, 8'hA5},
    {2'd2, 20'h01D20, 8'h00, 8'hA1},
    {2'd2, 20'h01DE0, 8'h00, 8'hA7},
    {2'd2, 20'h01E00, 8'h00, 8'hC3},
    {2'd2, 20'h01FFF, 8'h00, 8'hC3},
    {2'd2, 20'h01880, 8'h00, 8'hFF},
    {2'd2, 20'h01C40, 8'h00, 8'hFF},
    {2'd2, 20'h03FFF, 8'h00, 8'hFF}
  };

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input bit r, input bit w, input logic [19:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = r; bus_wr = w; bus_wdata = d;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = '0; rom_en = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R4 reset ctrl", {1'b0, ctrl_q}, 9'h000);
    check("R8 reset stat_set", {8'h0, stat_set}, 9'h000);
    check("R10 reset rdata", {1'b0, bus_rdata}, 9'h0FF);

    // table walk: R1 R2 R3 R4 R5 R6 R7 R9
    for (int i = 0; i < NV; i++) begin
      cyc(VEC[i][37:36] == 2'd2, VEC[i][37:36] == 2'd1, VEC[i][35:16], VEC[i][15:8]);
      if (VEC[i][37:36] == 2'd2)
        check($sformatf("R1-R9 vector %0d", i), {1'b0, bus_rdata}, {1'b0, VEC[i][7:0]});
    end

    // R10 hold across idle
    repeat (2) @(negedge clk);
    check("R10 hold", {1'b0, bus_rdata}, 9'h0FF);

    // R2 ROM disabled
    rom_en = 1'b0;
    cyc(1, 0, 20'h00123, 8'h00);
    check("R2 rom disabled", {1'b0, bus_rdata}, 9'h0FF);
    rom_en = 1'b1;

    // R8 rising edge of ctrl bit 1
    cyc(0, 1, 20'h01C00, 8'h00);
    check("R8 no set on clear", {8'h0, stat_set}, 9'h000);
    cyc(0, 1, 20'h01C10, 8'h02);
    check("R8 set pulse", {8'h0, stat_set}, 9'h001);
    @(negedge clk);
    check("R8 pulse one cycle", {8'h0, stat_set}, 9'h000);
    cyc(0, 1, 20'h01C00, 8'h03);
    check("R8 no set when already high", {8'h0, stat_set}, 9'h000);
    check("R4 ctrl written", {1'b0, ctrl_q}, 9'h003);

    // R9 ignored writes
    cyc(0, 1, 20'h01880, 8'h11);
    cyc(1, 0, 20'h01800, 8'h00);
    check("R9 unmapped write ignored", {1'b0, bus_rdata}, 9'h0A5);
    @(negedge clk);
    bus_addr = 20'h00000; bus_wr = 1'b1; bus_wdata = 8'h55;
    #1;
    check("R9 rom write no strobes", {5'h0, ctl_wr, dp_wr, ctl_rd, dp_rd}, 9'h000);
    @(negedge clk);
    bus_wr = 1'b0;
    check("R9 rom write ctrl kept", {1'b0, ctrl_q}, 9'h003);

    // R6 controller strobe
    @(negedge clk);
    bus_addr = 20'h01D60; bus_wr = 1'b1;
    #1;
    check("R6 ctl_wr/idx", {4'h0, ctl_wr, dp_wr, ctl_idx}, {4'h0, 1'b1, 1'b0, 3'd3});
    @(negedge clk);
    bus_wr = 1'b0;
    #1;
    check("R6 strobe drops", {7'h0, ctl_wr, ctl_rd}, 9'h000);

    // R7 data port strobe
    @(negedge clk);
    bus_addr = 20'h01E05; bus_rd = 1'b1;
    #1;
    check("R7 dp_rd", {7'h0, dp_rd, ctl_rd}, 9'h002);
    check("R7 dp_off", dp_off, 9'h005);
    @(negedge clk);
    bus_rd = 1'b0;
    check("R7 dp read data", {1'b0, bus_rdata}, 9'h0C3);

    // R11 simultaneous read and write
    cyc(0, 1, 20'h01805, 8'h11);
    cyc(1, 1, 20'h01805, 8'h22);
    check("R11 ram old value", {1'b0, bus_rdata}, 9'h011);
    cyc(1, 0, 20'h01805, 8'h00);
    check("R11 ram new value", {1'b0, bus_rdata}, 9'h022);
    cyc(0, 1, 20'h01C00, 8'h00);
    cyc(1, 1, 20'h01C00, 8'h02);
    check("R11 ctrl old value", {1'b0, bus_rdata}, 9'h000);
    check("R8 set with overlap", {8'h0, stat_set}, 9'h001);
    cyc(1, 0, 20'h01C00, 8'h00);
    check("R11 ctrl new value", {1'b0, bus_rdata}, 9'h002);

    // R4 reset clears control
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check("R4 ctrl cleared by reset", {1'b0, ctrl_q}, 9'h000);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule